// File: doc/BRIEF.md
# Asynchronous Static Memory Bus Controller

This block takes one transaction at a time from a simple internal request port and carries it out on an external 16-bit static memory bus. The bus is asynchronous, non-page and non-multiplexed. The reference clock is the controller clock itself: it is divided by one, so every timing field counts controller clock cycles. The block drives one active-low select line per device, plus output-enable, write-enable, address-valid, byte-lane enables, a halfword address, and a split data bus with a separate drive-enable.

Each select line has its own timing fields: read strobe length, output-enable lead and trail, write-enable lead and width, address-valid width, turnaround length and a turnaround mode bit. The transaction's select index chooses which set applies. A field left at zero gives the shortest legal pulse. A select line can also be marked narrow. A single-byte write to a narrow device becomes a halfword read, a merge of the byte into the lane chosen by address bit 0, and a halfword write.

Top module: `smc_async_ctrl`

## Requirements
- R1: While reset is high, and after it is released, every select line, `mem_oe_n`, `mem_we_n` and `mem_adv_n` is 1, `mem_dq_oe` is 0, `rsp_done` is 0 and `req_ready` is 1.
- R2: A read holds its select line low for `rd_len+1` cycles. Counting the first select-low cycle as offset 0, `mem_oe_n` is low from offset `oe_lead` through offset `rd_len-oe_trail` and high on all other cycles. The configuration must satisfy `oe_lead+oe_trail <= rd_len`.
- R3: Read data is sampled from `mem_dq_i` at the clock edge that ends the last cycle with `mem_oe_n` low. It is returned on `rsp_rdata`, together with a one-cycle `rsp_done` pulse, in the first cycle after the select line returns high. A plain write also pulses `rsp_done` in that same position.
- R4: A write holds its select line low for `wr_lead+we_width+2` cycles. `mem_we_n` is high for the first `wr_lead` of them, low for the next `we_width+1`, and high for the final hold cycle. `mem_dq_oe` is 1 in exactly the select-low cycles of writes.
- R5: `mem_adv_n` goes low in the first select-low cycle of every access. It stays low for `min(adv_width+1, access length)` cycles.
- R6: A byte write (`req_byte`=1) to a select line whose narrow bit is 0 is a single write. The byte is taken from `req_wdata[7:0]` and placed on both halves of `mem_dq_o`. `mem_be_n` is 2'b10 (low lane only) when `req_addr[0]`=0 and 2'b01 (high lane only) when `req_addr[0]`=1. All other accesses use `mem_be_n`=2'b00.
- R7: A byte write to a select line whose narrow bit is 1 is done as a halfword read, then a halfword write with `mem_be_n`=2'b00. The written halfword is the read value with the lane chosen by `req_addr[0]` replaced by `req_wdata[7:0]`. `rsp_done` pulses once, after the write.
- R8: If a request is waiting, the number of all-high select cycles between two accesses is `turn_len+1` of the earlier access's select line. This applies after a read, and also after a write when that line's `turn_all` bit is 1. In every other case it is 1.
- R9: Only the select line `mem_cs_n[req_cs]` goes low, with that line's timing fields. `mem_addr` carries `req_addr[AW-1:1]`.
- R10: `req_ready` drops in the cycle after a request is accepted and stays low until the transaction, including any turnaround, is over.
- R11: `mem_oe_n` and `mem_we_n` are never low together. Neither strobe nor `mem_adv_n` is ever low while all select lines are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (also the reference clock) |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | Write is a single byte |
| req_cs | input | CSW | Select line index |
| req_addr | input | AW | Byte address |
| req_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_done of a read |
| cfg_rd_len | input | NCS*TW | Per-line read strobe length field |
| cfg_oe_lead | input | NCS*TW | Per-line select-to-output-enable delay |
| cfg_oe_trail | input | NCS*TW | Per-line output-enable release before select |
| cfg_wr_lead | input | NCS*TW | Per-line cycles before write-enable falls |
| cfg_we_width | input | NCS*TW | Per-line write-enable width field |
| cfg_adv_width | input | NCS*TW | Per-line address-valid width field |
| cfg_turn_len | input | NCS*TW | Per-line turnaround length |
| cfg_turn_all | input | NCS | Per-line: turnaround after writes too |
| cfg_narrow | input | NCS | Per-line: byte writes use read-merge-write |
| mem_cs_n | output | NCS | Active-low select lines |
| mem_oe_n | output | 1 | Active-low output-enable |
| mem_we_n | output | 1 | Active-low write-enable |
| mem_adv_n | output | 1 | Active-low address-valid |
| mem_be_n | output | 2 | Active-low byte-lane enables (bit 0 = low byte) |
| mem_addr | output | AW-1 | Halfword address |
| mem_dq_o | output | 16 | Data driven toward memory |
| mem_dq_i | input | 16 | Data returned by memory |
| mem_dq_oe | output | 1 | Data bus drive enable |

## Verification
The bench runs one select line with a short output-enable window and one with a zero-length window. A design that sampled read data one cycle late would return the memory model's idle pattern, and an off-by-one in any strobe offset would shift a measured edge. An address-valid field longer than the access shows whether the pulse is clipped at the end of the select window. Turnaround is measured on back-to-back traffic after reads and after writes in both modes, so a gap rule applied to the wrong access type changes the counted high cycles. Narrow-line byte writes to both lanes, each followed by a read-back, expose a merge into the wrong lane, a lost old byte, or an early completion pulse after the read phase.

// File: rtl/smc_pkg.sv
package smc_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RD   = 3'd1,
    S_WR   = 3'd2,
    S_GAP  = 3'd3,
    S_MRG  = 3'd4
  } seq_st_t;

  localparam int HW = 16;

endpackage

// File: rtl/smc_cfg_mux.sv
module smc_cfg_mux #(
  parameter int NCS = 2,
  parameter int TW  = 4,
  parameter int CSW = 1
) (
  input  logic [CSW-1:0]    sel,
  input  logic [NCS*TW-1:0] f_rd_len,
  input  logic [NCS*TW-1:0] f_oe_lead,
  input  logic [NCS*TW-1:0] f_oe_trail,
  input  logic [NCS*TW-1:0] f_wr_lead,
  input  logic [NCS*TW-1:0] f_we_width,
  input  logic [NCS*TW-1:0] f_adv_width,
  input  logic [NCS*TW-1:0] f_turn_len,
  input  logic [NCS-1:0]    f_turn_all,
  output logic [TW-1:0]     rd_len,
  output logic [TW-1:0]     oe_lead,
  output logic [TW-1:0]     oe_trail,
  output logic [TW-1:0]     wr_lead,
  output logic [TW-1:0]     we_width,
  output logic [TW-1:0]     adv_width,
  output logic [TW-1:0]     turn_len,
  output logic              turn_all
);

  always_comb begin
    rd_len    = f_rd_len[sel*TW +: TW];
    oe_lead   = f_oe_lead[sel*TW +: TW];
    oe_trail  = f_oe_trail[sel*TW +: TW];
    wr_lead   = f_wr_lead[sel*TW +: TW];
    we_width  = f_we_width[sel*TW +: TW];
    adv_width = f_adv_width[sel*TW +: TW];
    turn_len  = f_turn_len[sel*TW +: TW];
    turn_all  = f_turn_all[sel];
  end

endmodule

// File: rtl/smc_byte_merge.sv
module smc_byte_merge (
  input  logic [15:0] old_hw,
  input  logic [7:0]  new_byte,
  input  logic        hi_lane,
  output logic [15:0] merged
);

  always_comb begin
    if (hi_lane) merged = {new_byte, old_hw[7:0]};
    else         merged = {old_hw[15:8], new_byte};
  end

endmodule

// File: rtl/smc_async_ctrl.sv
module smc_async_ctrl #(
  parameter int NCS = 2,
  parameter int TW  = 4,
  parameter int AW  = 12,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic              req_byte,
  input  logic [CSW-1:0]    req_cs,
  input  logic [AW-1:0]     req_addr,
  input  logic [15:0]       req_wdata,
  output logic              rsp_done,
  output logic [15:0]       rsp_rdata,
  input  logic [NCS*TW-1:0] cfg_rd_len,
  input  logic [NCS*TW-1:0] cfg_oe_lead,
  input  logic [NCS*TW-1:0] cfg_oe_trail,
  input  logic [NCS*TW-1:0] cfg_wr_lead,
  input  logic [NCS*TW-1:0] cfg_we_width,
  input  logic [NCS*TW-1:0] cfg_adv_width,
  input  logic [NCS*TW-1:0] cfg_turn_len,
  input  logic [NCS-1:0]    cfg_turn_all,
  input  logic [NCS-1:0]    cfg_narrow,
  output logic [NCS-1:0]    mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_adv_n,
  output logic [1:0]        mem_be_n,
  output logic [AW-2:0]     mem_addr,
  output logic [15:0]       mem_dq_o,
  input  logic [15:0]       mem_dq_i,
  output logic              mem_dq_oe
);
  import smc_pkg::*;

  localparam int CW = TW + 2;

  seq_st_t          st;
  logic [CW-1:0]    cnt;
  logic [CSW-1:0]   cur_cs;
  logic [AW-2:0]    cur_addr;
  logic             cur_lane;
  logic             byte_wr;
  logic             rmw;
  logic [15:0]      wdata_q;
  logic [15:0]      rbuf;
  logic             samp_q;
  logic             last_q;

  logic [TW-1:0] s_rd_len, s_oe_lead, s_oe_trail, s_wr_lead;
  logic [TW-1:0] s_we_width, s_adv_width, s_turn_len;
  logic          s_turn_all;
  logic [CW-1:0] e_rd, e_oel, e_oet, e_wrl, e_wel, e_adv, e_turn, e_wlast;
  logic [CW-1:0] acc_last;
  logic          acc_on, gap_req, narrow_req;
  logic [15:0]   mrg_hw;

  smc_cfg_mux #(.NCS(NCS), .TW(TW), .CSW(CSW)) u_cfg (
    .sel(cur_cs),
    .f_rd_len(cfg_rd_len), .f_oe_lead(cfg_oe_lead), .f_oe_trail(cfg_oe_trail),
    .f_wr_lead(cfg_wr_lead), .f_we_width(cfg_we_width),
    .f_adv_width(cfg_adv_width), .f_turn_len(cfg_turn_len),
    .f_turn_all(cfg_turn_all),
    .rd_len(s_rd_len), .oe_lead(s_oe_lead), .oe_trail(s_oe_trail),
    .wr_lead(s_wr_lead), .we_width(s_we_width), .adv_width(s_adv_width),
    .turn_len(s_turn_len), .turn_all(s_turn_all)
  );

  smc_byte_merge u_mrg (
    .old_hw(rbuf), .new_byte(wdata_q[7:0]), .hi_lane(cur_lane), .merged(mrg_hw)
  );

  always_comb begin
    e_rd     = CW'(s_rd_len);
    e_oel    = CW'(s_oe_lead);
    e_oet    = CW'(s_oe_trail);
    e_wrl    = CW'(s_wr_lead);
    e_wel    = CW'(s_we_width);
    e_adv    = CW'(s_adv_width);
    e_turn   = CW'(s_turn_len);
    e_wlast  = e_wrl + e_wel + CW'(1);
    acc_on   = (st == S_RD) || (st == S_WR);
    acc_last = (st == S_RD) ? e_rd : e_wlast;
    gap_req  = ((st == S_RD) || s_turn_all) && (s_turn_len != '0);
    narrow_req = req_we && req_byte && cfg_narrow[req_cs];
  end

  assign req_ready = (st == S_IDLE);
  assign rsp_rdata = rbuf;

  // sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cnt      <= '0;
      cur_cs   <= '0;
      cur_addr <= '0;
      cur_lane <= 1'b0;
      byte_wr  <= 1'b0;
      rmw      <= 1'b0;
      wdata_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          cur_cs   <= req_cs;
          cur_addr <= req_addr[AW-1:1];
          cur_lane <= req_addr[0];
          wdata_q  <= req_wdata;
          byte_wr  <= req_we && req_byte;
          rmw      <= narrow_req;
          cnt      <= '0;
          st       <= (!req_we || narrow_req) ? S_RD : S_WR;
        end
        S_RD, S_WR: begin
          if (cnt == acc_last) begin
            cnt <= '0;
            if (gap_req)                  st <= S_GAP;
            else if (st == S_RD && rmw)   st <= S_MRG;
            else                          st <= S_IDLE;
            if (st == S_WR) rmw <= 1'b0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_GAP: begin
          if (cnt + CW'(1) == e_turn) begin
            cnt <= '0;
            st  <= rmw ? S_MRG : S_IDLE;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_MRG: begin
          cnt <= '0;
          st  <= S_WR;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // select lines, one register each
  for (genvar gi = 0; gi < NCS; gi++) begin : g_cs
    always_ff @(posedge clk) begin
      if (rst) mem_cs_n[gi] <= 1'b1;
      else     mem_cs_n[gi] <= !(acc_on && (cur_cs == CSW'(gi)));
    end
  end

  // pin register stage
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_adv_n <= 1'b1;
      mem_be_n  <= 2'b00;
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
      samp_q    <= 1'b0;
      last_q    <= 1'b0;
      rsp_done  <= 1'b0;
      rbuf      <= '0;
    end else begin
      mem_oe_n  <= !((st == S_RD) && (cnt >= e_oel) && (cnt + e_oet <= e_rd));
      mem_we_n  <= !((st == S_WR) && (cnt >= e_wrl) && (cnt <= e_wrl + e_wel));
      mem_adv_n <= !(acc_on && (cnt <= e_adv));
      mem_dq_oe <= (st == S_WR);
      mem_addr  <= cur_addr;
      if (rmw)          mem_dq_o <= mrg_hw;
      else if (byte_wr) mem_dq_o <= {wdata_q[7:0], wdata_q[7:0]};
      else              mem_dq_o <= wdata_q;
      if ((st == S_WR) && byte_wr && !rmw) mem_be_n <= cur_lane ? 2'b01 : 2'b10;
      else                                 mem_be_n <= 2'b00;
      samp_q   <= (st == S_RD) && (cnt + e_oet == e_rd);
      last_q   <= acc_on && (cnt == acc_last) && !((st == S_RD) && rmw);
      rsp_done <= last_q;
      if (samp_q) rbuf <= mem_dq_i;
    end
  end

endmodule

module smc_async_ctrl_chk #(
  parameter int NCS = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           req_valid,
  input logic           req_ready,
  input logic           rsp_done,
  input logic [NCS-1:0] mem_cs_n,
  input logic           mem_oe_n,
  input logic           mem_we_n,
  input logic           mem_adv_n,
  input logic           mem_dq_oe
);
  logic cs_act;
  assign cs_act = |(~mem_cs_n);

  p_one_line_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_cs_n));

  p_no_contention_r11: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));

  p_strobe_inside_r11: assert property (@(posedge clk) disable iff (rst)
    (!mem_oe_n || !mem_we_n || !mem_adv_n) |-> cs_act);

  p_drive_in_write_r4: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (cs_act && mem_oe_n));

  p_we_hold_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> cs_act);

  p_adv_with_cs_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_act) |-> !mem_adv_n);

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

endmodule

bind smc_async_ctrl smc_async_ctrl_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_done(rsp_done), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_adv_n(mem_adv_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/tb_smc_async_ctrl.sv
module tb_smc_async_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NCS = 2;
  localparam int TW  = 4;
  localparam int AW  = 12;
  localparam int CSW = 1;

  typedef struct {
    int cs; int idx; int len; int oe_f; int oe_l; int we_f; int we_l;
    int adv; int gap; int data; int be; int dqc;
  } acc_t;
  typedef struct { bit rd; int data; } done_t;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_we = 1'b0, req_byte = 1'b0;
  logic [CSW-1:0] req_cs = '0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_done;
  logic [15:0] rsp_rdata;
  logic [NCS*TW-1:0] c_rd = '0, c_oel = '0, c_oet = '0, c_wrl = '0, c_wel = '0, c_adv = '0, c_turn = '0;
  logic [NCS-1:0] c_all = '0, c_nar = '0;
  logic [NCS-1:0] mem_cs_n;
  logic mem_oe_n, mem_we_n, mem_adv_n, mem_dq_oe;
  logic [1:0] mem_be_n;
  logic [AW-2:0] mem_addr;
  logic [15:0] mem_dq_o, mem_dq_i;

  logic [15:0] md [NCS][64];
  logic [15:0] sh [NCS][64];
  acc_t  sq[$];
  done_t dq[$];
  int checks = 0, fails = 0, cyc = 0;
  int prev_kind = 0, prev_cs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smc_async_ctrl #(.NCS(NCS), .TW(TW), .AW(AW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_byte(req_byte), .req_cs(req_cs), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .cfg_rd_len(c_rd), .cfg_oe_lead(c_oel), .cfg_oe_trail(c_oet),
    .cfg_wr_lead(c_wrl), .cfg_we_width(c_wel), .cfg_adv_width(c_adv),
    .cfg_turn_len(c_turn), .cfg_turn_all(c_all), .cfg_narrow(c_nar),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_adv_n(mem_adv_n), .mem_be_n(mem_be_n), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i), .mem_dq_oe(mem_dq_oe)
  );

  // memory model: drives data only while output-enable is low
  logic cs_act;
  int   csi;
  assign cs_act = |(~mem_cs_n);
  assign csi = (mem_cs_n[1] == 1'b0) ? 1 : 0;
  assign mem_dq_i = (!mem_oe_n && cs_act) ? md[csi][mem_addr[5:0]] : 16'h0BAD;

  always @(posedge clk) begin
    if (cs_act && !mem_we_n) begin
      if (!mem_be_n[0]) md[csi][mem_addr[5:0]][7:0]  = mem_dq_o[7:0];
      if (!mem_be_n[1]) md[csi][mem_addr[5:0]][15:8] = mem_dq_o[15:8];
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  function automatic int fld(logic [NCS*TW-1:0] v, int cs);
    return int'(v[cs*TW +: TW]);
  endfunction

  task automatic set_cfg(int cs, int rd, int oel, int oet, int wrl, int wel,
                         int adv, int turn, bit all, bit nar);
    c_rd[cs*TW +: TW]  = TW'(rd);   c_oel[cs*TW +: TW] = TW'(oel);
    c_oet[cs*TW +: TW] = TW'(oet);  c_wrl[cs*TW +: TW] = TW'(wrl);
    c_wel[cs*TW +: TW] = TW'(wel);  c_adv[cs*TW +: TW] = TW'(adv);
    c_turn[cs*TW +: TW] = TW'(turn);
    c_all[cs] = all; c_nar[cs] = nar;
  endtask

  function automatic int min2(int a, int b); return (a < b) ? a : b; endfunction

  task automatic push_rd(int cs, int idx, int gap);
    acc_t a;
    a.cs = cs; a.idx = idx; a.len = fld(c_rd, cs) + 1;
    a.oe_f = fld(c_oel, cs); a.oe_l = fld(c_rd, cs) - fld(c_oet, cs);
    a.we_f = -1; a.we_l = -1; a.adv = min2(fld(c_adv, cs) + 1, a.len);
    a.gap = gap; a.data = 0; a.be = 0; a.dqc = 0;
    sq.push_back(a);
  endtask

  task automatic push_wr(int cs, int idx, int gap, int data, int be);
    acc_t a;
    a.cs = cs; a.idx = idx; a.len = fld(c_wrl, cs) + fld(c_wel, cs) + 2;
    a.oe_f = -1; a.oe_l = -1; a.we_f = fld(c_wrl, cs);
    a.we_l = fld(c_wrl, cs) + fld(c_wel, cs); a.adv = min2(fld(c_adv, cs) + 1, a.len);
    a.gap = gap; a.data = data; a.be = be; a.dqc = a.len;
    sq.push_back(a);
  endtask

  // driver: pushes expectations, then performs the handshake
  task automatic send(int cs, bit we, bit bw, int addr, int d, bit b2b);
    int idx, gap;
    logic [15:0] old, nw;
    done_t dn;
    idx = (addr >> 1) & 63;
    if (!b2b || prev_kind == 0) gap = -1;
    else if (prev_kind == 1 || c_all[prev_cs]) gap = fld(c_turn, prev_cs) + 1;
    else gap = 1;
    old = sh[cs][idx];
    nw = (addr & 1) ? {d[7:0], old[7:0]} : {old[15:8], d[7:0]};
    if (!we) begin
      push_rd(cs, idx, gap); dn.rd = 1'b1; dn.data = int'(old); prev_kind = 1;
    end else if (!bw) begin
      push_wr(cs, idx, gap, d & 16'hFFFF, 0); sh[cs][idx] = d[15:0];
      dn.rd = 1'b0; dn.data = 0; prev_kind = 2;
    end else if (c_nar[cs]) begin
      push_rd(cs, idx, gap);
      push_wr(cs, idx, fld(c_turn, cs) + 1, int'(nw), 0);
      sh[cs][idx] = nw; dn.rd = 1'b0; dn.data = 0; prev_kind = 2;
    end else begin
      push_wr(cs, idx, gap, int'({d[7:0], d[7:0]}), (addr & 1) ? 1 : 2);
      sh[cs][idx] = nw; dn.rd = 1'b0; dn.data = 0; prev_kind = 2;
    end
    dq.push_back(dn);
    prev_cs = cs;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_byte = bw; req_cs = CSW'(cs);
    req_addr = AW'(addr); req_wdata = d[15:0];
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: measures each select window and each completion
  int in_acc = 0, idx_c = 0, high_cnt = 1000, w_gap = 0, w_cs = 0, w_idx = 0;
  int m_oef, m_oel, m_wef, m_wel, m_adv, m_dqc, m_data, m_be;
  always @(negedge clk) begin
    if (!rst) begin
      if (!mem_oe_n && !mem_we_n) chk("R11 strobes overlap", 1, 0);
      if (!cs_act && (!mem_oe_n || !mem_we_n || !mem_adv_n)) chk("R11 strobe outside select", 1, 0);
      if (!cs_act && mem_dq_oe) chk("R4 data driven with select high", 1, 0);
      if (cs_act) begin
        if (!in_acc) begin
          in_acc = 1; idx_c = 0; w_gap = high_cnt; w_cs = csi; w_idx = int'(mem_addr);
          m_oef = -1; m_oel = -1; m_wef = -1; m_wel = -1; m_adv = 0; m_dqc = 0;
          m_data = 0; m_be = 0;
        end
        if (!mem_oe_n) begin if (m_oef < 0) m_oef = idx_c; m_oel = idx_c; end
        if (!mem_we_n) begin
          if (m_wef < 0) m_wef = idx_c; m_wel = idx_c;
          m_data = int'(mem_dq_o); m_be = int'(mem_be_n);
        end
        if (!mem_adv_n) m_adv++;
        if (mem_dq_oe) m_dqc++;
        idx_c++;
      end else begin
        if (in_acc) begin
          in_acc = 0; high_cnt = 1;
          if (sq.size() == 0) chk("R10 unexpected access", 1, 0);
          else begin
            acc_t e;
            e = sq.pop_front();
            chk("R9 select line", w_cs, e.cs);
            chk("R9 halfword address", w_idx, e.idx);
            chk(e.we_f < 0 ? "R2 read select length" : "R4 write select length", idx_c, e.len);
            chk("R2 oe first offset", m_oef, e.oe_f);
            chk("R2 oe last offset", m_oel, e.oe_l);
            chk("R4 we first offset", m_wef, e.we_f);
            chk("R4 we last offset", m_wel, e.we_l);
            chk("R5 adv width", m_adv, e.adv);
            chk("R4 drive cycles", m_dqc, e.dqc);
            if (e.gap >= 0) chk("R8 turnaround cycles", w_gap, e.gap);
            if (e.we_f >= 0) begin
              chk(e.be == 0 ? "R7 write data" : "R6 byte write data", m_data, e.data);
              chk(e.be == 0 ? "R7 lane enables" : "R6 lane enables", m_be, e.be);
            end
          end
        end else if (high_cnt < 1000) high_cnt++;
      end
      if (rsp_done) begin
        chk("R3 done one cycle after select release", high_cnt, 1);
        if (dq.size() == 0) chk("R7 extra done pulse", 1, 0);
        else begin
          done_t r;
          r = dq.pop_front();
          if (r.rd) chk("R3 read data", int'(rsp_rdata), r.data);
        end
      end
    end
  end

  task automatic wait_idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < NCS; c++)
      for (int i = 0; i < 64; i++) begin
        md[c][i] = 16'((i * 16'h0123) ^ 16'hA5C3) + 16'(c);
        sh[c][i] = md[c][i];
      end
    set_cfg(0, 5, 1, 1, 2, 1, 1, 2, 1'b0, 1'b0);
    set_cfg(1, 3, 0, 0, 0, 0, 6, 3, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    // R1: reset state while reset held
    chk("R1 select lines in reset", int'(mem_cs_n), 3);
    chk("R1 strobes in reset", int'({mem_oe_n, mem_we_n, mem_adv_n}), 7);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 select lines after reset", int'(mem_cs_n), 3);
    chk("R1 drive enable after reset", int'(mem_dq_oe), 0);
    chk("R1 done after reset", int'(rsp_done), 0);
    chk("R1 ready after reset", int'(req_ready), 1);

    // line 0: full write, reads, normal byte writes on both lanes
    send(0, 1, 0, 'h10, 'h1234, 0);
    send(0, 0, 0, 'h10, 0, 1);
    chk("R10 ready low while busy", int'(req_ready), 0);
    send(0, 0, 0, 'h22, 0, 1);
    send(0, 1, 1, 'h23, 'hAB, 1);
    send(0, 1, 1, 'h26, 'hC7, 1);
    send(0, 0, 0, 'h22, 0, 1);
    send(0, 0, 0, 'h26, 0, 1);
    // line 1: narrow read-merge-write on both lanes, turnaround after writes
    send(1, 1, 1, 'h30, 'h5C, 1);
    send(1, 0, 0, 'h30, 0, 1);
    send(1, 1, 1, 'h33, 'h9E, 1);
    send(1, 0, 0, 'h32, 0, 1);
    send(1, 1, 0, 'h40, 'hBEEF, 1);
    send(1, 1, 0, 'h42, 'h0F0F, 1);
    send(0, 1, 0, 'h44, 'h7788, 1);
    send(0, 0, 0, 'h44, 0, 1);
    send(1, 0, 0, 'h42, 0, 1);
    wait_idle(40);
    // minimum timing: every field left at zero on line 0
    set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 1'b0, 1'b0);
    send(0, 1, 0, 'h50, 'hA1B2, 0);
    send(0, 0, 0, 'h50, 0, 1);
    send(0, 0, 0, 'h52, 0, 1);
    send(0, 1, 1, 'h51, 'h3D, 1);
    send(0, 0, 0, 'h50, 0, 1);
    wait_idle(60);
    chk("R10 all expected accesses seen", sq.size(), 0);
    chk("R3 all expected completions seen", dq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc == 100000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

endmodule